// File: doc/BRIEF.md
# LCD Frame Refresh Controller

The block streams a frame buffer held in memory to a passive-matrix LCD panel. It reads 32-bit words through a simple request/valid read port. It shifts each word out as 4-bit nibbles on the panel data bus, starting with the most significant nibble. It emits a line strobe at the end of every row of pixel groups and a frame strobe at the end of the last row. It also drives the alternating bias signal that the panel needs to avoid DC stress.

Plain configuration inputs set up the controller. They give the panel geometry in pixels, the pixel depth, split-panel mode, the frame-buffer window in bytes, data inversion and the bias rate. The block derives the group count per line and the number of lines itself. Two enables gate the refresh. A freeze request lets the current frame complete and then parks the engine until software cycles the video enable.

Top module: `lcd_refresh_ctrl`

## Requirements
- R1: `depth_sel` encodes 0 = monochrome, 1 = 2-bit grey, 2 = 4-bit grey, 3 = 8-bit color. A line is G+1 nibbles long. G = (width/8)*3 − 1 when depth is 3 and `split_mode` is 0, and G = width/4 − 1 in every other case. `line_strobe` is high in the cycle of the last nibble of each line.
- R2: A frame is L+1 lines long, with L = height − 1, or height/2 − 1 when `split_mode` is 1. `frame_strobe` is high together with `line_strobe` on the last nibble of the frame.
- R3: Each fetched 32-bit word goes out one nibble per `pix_clk` cycle, bits [31:28] first and bits [3:0] last. A frame strobe discards the rest of the word.
- R4: With `invert` at 1, `pnl_data` is the bitwise complement of the nibble. With `invert` at 0, the nibble passes through unchanged.
- R5: Fetches start at `fb_start` and step by 4 bytes. The next address returns to `fb_start` when start+4 would reach or pass `fb_end`, and also after every frame strobe. `mem_addr` holds steady while a request waits for `mem_valid`.
- R6: Refresh runs only while both `vid_en` and `disp_on` are 1. Otherwise `pnl_data`, `pix_clk`, both strobes and `mem_req` stay 0. Refresh always restarts at the top of a frame.
- R7: `df_out` is 0 while `vid_en` is 0.
- R8: With `df_mode` at 0, `df_out` toggles once after every frame strobe.
- R9: With `df_mode` at 1, `df_out` toggles after every `df_rate`+1 line strobes.
- R10: A frame strobe seen while `freeze_req` is 1 halts the engine: no further `pix_clk` or `mem_req`.
- R11: A halted engine stays halted after `freeze_req` is cleared. It resumes only once `vid_en` has been 0 and is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_en | input | 1 | Video logic enable |
| disp_on | input | 1 | Display drive enable |
| freeze_req | input | 1 | Halt at end of current frame |
| invert | input | 1 | Complement the panel data |
| split_mode | input | 1 | Split (dual-scan) panel |
| depth_sel | input | 2 | Pixel depth code (R1) |
| df_mode | input | 1 | 0: bias per frame, 1: bias per line count |
| df_rate | input | DF_W | Lines per bias toggle minus one |
| pnl_width | input | DIM_W | Panel width in pixels |
| pnl_height | input | DIM_W | Panel height in lines |
| fb_start | input | ADDR_W | First byte address of the buffer |
| fb_end | input | ADDR_W | Byte address just past the buffer |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | WORD_W | Read data |
| pnl_data | output | 4 | Panel data nibble |
| pix_clk | output | 1 | Nibble valid / shift pulse |
| line_strobe | output | 1 | Last nibble of a line |
| frame_strobe | output | 1 | Last nibble of a frame |
| df_out | output | 1 | Panel bias alternation |

## Verification
The bench targets several corner cases. In 8-bit unsplit geometry the group count is tripled, so a design that applies the plain width/4 rule strobes lines too early. An 18-nibble frame ends partway through a word, so a design that keeps shifting the old word sends wrong data at the top of the next frame. A buffer window smaller than one frame forces the end-address wrap mid-frame, which exposes an address that keeps climbing. The freeze sequence raises the request mid-frame, clears it while halted and only then cycles the enable: a design that halts at once cuts a frame short, and one that resumes when the request clears restarts too early. Line-mode bias with a rate of 1 catches an off-by-one in the bias period.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2
  } fetch_st_e;

  localparam logic [1:0] DEPTH_MONO   = 2'd0;
  localparam logic [1:0] DEPTH_GREY2  = 2'd1;
  localparam logic [1:0] DEPTH_GREY4  = 2'd2;
  localparam logic [1:0] DEPTH_COLOR8 = 2'd3;

endpackage

// File: rtl/lcdr_geom.sv
module lcdr_geom
  import lcdr_pkg::*;
#(
  parameter int DIM_W = 10
) (
  input  logic [DIM_W-1:0] width_px,
  input  logic [DIM_W-1:0] height_px,
  input  logic [1:0]       depth,
  input  logic             split,
  output logic [DIM_W-1:0] grp_max,
  output logic [DIM_W-1:0] line_max
);

  // last group index on a line; color without split packs R,G,B per pixel
  function automatic logic [DIM_W-1:0] groups_minus1(
    input logic [DIM_W-1:0] w, input logic [1:0] d, input logic s);
    logic [DIM_W+1:0] tripled;
    tripled = {2'b00, (w >> 3)} * (DIM_W+2)'(3);
    if (d == DEPTH_COLOR8 && !s) return tripled[DIM_W-1:0] - DIM_W'(1);
    return (w >> 2) - DIM_W'(1);
  endfunction

  // last line index; a split panel scans both halves at once
  function automatic logic [DIM_W-1:0] lines_minus1(
    input logic [DIM_W-1:0] h, input logic s);
    if (s) return (h >> 1) - DIM_W'(1);
    return h - DIM_W'(1);
  endfunction

  assign grp_max  = groups_minus1(width_px, depth, split);
  assign line_max = lines_minus1(height_px, split);

endmodule

// File: rtl/lcdr_timing.sv
module lcdr_timing #(
  parameter int DIM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             nib_tick,
  input  logic [DIM_W-1:0] grp_max,
  input  logic [DIM_W-1:0] line_max,
  output logic             line_end,
  output logic             frame_end
);

  logic [DIM_W-1:0] grp_cnt;
  logic [DIM_W-1:0] line_cnt;

  assign line_end  = nib_tick && (grp_cnt == grp_max);
  assign frame_end = line_end && (line_cnt == line_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_cnt  <= '0;
      line_cnt <= '0;
    end else if (clear) begin
      grp_cnt  <= '0;
      line_cnt <= '0;
    end else if (nib_tick) begin
      if (line_end) begin
        grp_cnt  <= '0;
        line_cnt <= frame_end ? '0 : line_cnt + DIM_W'(1);
      end else begin
        grp_cnt <= grp_cnt + DIM_W'(1);
      end
    end
  end

  AST_GROUP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (grp_cnt <= grp_max)); // R1

endmodule

// File: rtl/lcdr_fetch.sv
module lcdr_fetch
  import lcdr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [ADDR_W-1:0] fb_start,
  input  logic [ADDR_W-1:0] fb_end,
  input  logic              frame_end,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              nib_tick,
  output logic [3:0]        nib_data
);

  localparam int NIBS  = WORD_W / 4;
  localparam int IDX_W = $clog2(NIBS);
  localparam int STEP  = WORD_W / 8;

  fetch_st_e         state;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;

  function automatic logic [ADDR_W-1:0] advance(
    input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi);
    logic [ADDR_W:0] sum;
    sum = {1'b0, a} + (ADDR_W+1)'(STEP);
    if (sum >= {1'b0, hi}) return lo;
    return sum[ADDR_W-1:0];
  endfunction

  assign mem_req  = run && (state == ST_FETCH);
  assign mem_addr = addr;
  assign nib_tick = run && (state == ST_SHIFT);
  assign nib_data = shreg[WORD_W-1 -: 4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      addr  <= '0;
      shreg <= '0;
      idx   <= '0;
    end else if (!run) begin
      state <= ST_IDLE;
      addr  <= fb_start;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: state <= ST_FETCH;
        ST_FETCH: if (mem_valid) begin
          shreg <= mem_rdata;
          idx   <= '0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          shreg <= shreg << 4;
          idx   <= idx + IDX_W'(1);
          if (frame_end) begin
            addr  <= fb_start;
            state <= ST_FETCH;
          end else if (idx == IDX_W'(NIBS - 1)) begin
            addr  <= advance(addr, fb_start, fb_end);
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (!mem_req || $stable(mem_addr))); // R5
  AST_WORD_THEN_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (nib_tick || !run)); // R3
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (mem_addr == $past(fb_start))); // R5

endmodule

// File: rtl/lcdr_bias.sv
module lcdr_bias #(
  parameter int DF_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vid_en,
  input  logic            df_mode,
  input  logic [DF_W-1:0] df_rate,
  input  logic            line_end,
  input  logic            frame_end,
  output logic            df_out
);

  logic            df_q;
  logic [DF_W-1:0] lcnt;

  assign df_out = vid_en & df_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      df_q <= 1'b0;
      lcnt <= '0;
    end else if (!vid_en) begin
      df_q <= 1'b0;
      lcnt <= '0;
    end else if (!df_mode) begin
      lcnt <= '0;
      if (frame_end) df_q <= ~df_q;
    end else if (line_end) begin
      if (lcnt == df_rate) begin
        df_q <= ~df_q;
        lcnt <= '0;
      end else begin
        lcnt <= lcnt + DF_W'(1);
      end
    end
  end

  AST_DF_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && !df_mode && !frame_end) |=> $stable(df_q)); // R8

endmodule

// File: rtl/lcd_refresh_ctrl.sv
module lcd_refresh_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 10,
  parameter int DF_W   = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_en,
  input  logic              disp_on,
  input  logic              freeze_req,
  input  logic              invert,
  input  logic              split_mode,
  input  logic [1:0]        depth_sel,
  input  logic              df_mode,
  input  logic [DF_W-1:0]   df_rate,
  input  logic [DIM_W-1:0]  pnl_width,
  input  logic [DIM_W-1:0]  pnl_height,
  input  logic [ADDR_W-1:0] fb_start,
  input  logic [ADDR_W-1:0] fb_end,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [3:0]        pnl_data,
  output logic              pix_clk,
  output logic              line_strobe,
  output logic              frame_strobe,
  output logic              df_out
);

  logic             halted_q;
  logic             run;
  logic             nib_tick;
  logic [3:0]       nib_data;
  logic             line_end;
  logic             frame_end;
  logic [DIM_W-1:0] grp_max;
  logic [DIM_W-1:0] line_max;

  assign run = vid_en & disp_on & ~halted_q;

  // freeze takes effect only on the frame boundary; cleared by dropping enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       halted_q <= 1'b0;
    else if (!vid_en)                 halted_q <= 1'b0;
    else if (frame_end && freeze_req) halted_q <= 1'b1;
  end

  lcdr_geom #(.DIM_W(DIM_W)) u_geom (
    .width_px (pnl_width),
    .height_px(pnl_height),
    .depth    (depth_sel),
    .split    (split_mode),
    .grp_max  (grp_max),
    .line_max (line_max)
  );

  lcdr_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .fb_start (fb_start),
    .fb_end   (fb_end),
    .frame_end(frame_end),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_valid(mem_valid),
    .mem_rdata(mem_rdata),
    .nib_tick (nib_tick),
    .nib_data (nib_data)
  );

  lcdr_timing #(.DIM_W(DIM_W)) u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (~run),
    .nib_tick (nib_tick),
    .grp_max  (grp_max),
    .line_max (line_max),
    .line_end (line_end),
    .frame_end(frame_end)
  );

  lcdr_bias #(.DF_W(DF_W)) u_bias (
    .clk      (clk),
    .rst_n    (rst_n),
    .vid_en   (vid_en),
    .df_mode  (df_mode),
    .df_rate  (df_rate),
    .line_end (line_end),
    .frame_end(frame_end),
    .df_out   (df_out)
  );

  assign pix_clk      = nib_tick;
  assign pnl_data     = nib_tick ? (nib_data ^ {4{invert}}) : 4'b0000;
  assign line_strobe  = line_end;
  assign frame_strobe = frame_end;

  AST_HALT_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && freeze_req) |=> (!pix_clk && !mem_req)); // R10
  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (!mem_req && !pix_clk && pnl_data == 4'b0000)); // R6

endmodule

// File: tb/lcd_refresh_ctrl_test.sv
module lcd_refresh_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 10;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          vid_en = 0, disp_on = 0, freeze_req = 0, invert = 0, split_mode = 0;
  logic [1:0]    depth_sel = 0;
  logic          df_mode = 0;
  logic [FW-1:0] df_rate = 0;
  logic [DW-1:0] pnl_width = 16, pnl_height = 4;
  logic [AW-1:0] fb_start = 16'h0100, fb_end = 16'h0200;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 0;
  logic [31:0]   mem_rdata = 0;
  logic [3:0]    pnl_data;
  logic          pix_clk, line_strobe, frame_strobe, df_out;

  lcd_refresh_ctrl uut (.*);

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(input logic [AW-1:0] a);
    return {a, ~a} ^ 32'h5A3C_96E1;
  endfunction

  // geometry restated from the requirements
  function automatic int exp_gmax();
    if (depth_sel == 2'd3 && !split_mode) return (int'(pnl_width) * 3) / 8 - 1;
    return int'(pnl_width) / 4 - 1;
  endfunction
  function automatic int exp_lmax();
    return (split_mode ? int'(pnl_height) / 2 : int'(pnl_height)) - 1;
  endfunction

  // memory: answers each request after lat idle cycles
  int lat = 0, wcnt = 0;
  always @(posedge clk) begin
    #1;
    if (mem_valid) mem_valid = 1'b0;
    else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_valid = 1'b1;
        mem_rdata = mword(mem_addr);
        wcnt = 0;
      end else wcnt++;
    end
  end

  // behavioural reference, compared every cycle
  int m_grp = 0, m_ln = 0, m_idx = 0, m_dl = 0, m_frames = 0, m_ticks = 0;
  logic [AW-1:0] m_addr = 0;
  bit m_halt = 0, m_df = 0;

  always @(negedge clk) if (rst_n) begin : model
    bit run_in, e_line, e_frame;
    logic [3:0] e_nib;
    run_in = vid_en && disp_on && !m_halt;
    chk(df_out == (vid_en ? m_df : 1'b0), df_mode ? "R9 df" : "R7/R8 df", df_out, vid_en ? m_df : 1'b0);
    if (mem_req && mem_valid) chk(mem_addr == m_addr, "R5 fetch address", mem_addr, m_addr);
    if (!run_in) begin
      chk(!pix_clk && !mem_req && pnl_data == 0 && !line_strobe && !frame_strobe,
          m_halt ? "R10/R11 halted quiet" : "R6 quiet", {pix_clk, mem_req, pnl_data}, 0);
    end else if (pix_clk) begin
      m_ticks++;
      e_nib = 4'((mword(m_addr) >> (28 - 4 * m_idx)) & 32'hF) ^ {4{invert}};
      e_line = (m_grp == exp_gmax());
      e_frame = e_line && (m_ln == exp_lmax());
      chk(pnl_data == e_nib, invert ? "R4 inverted nibble" : "R3 nibble", pnl_data, e_nib);
      chk(line_strobe == e_line, "R1 line strobe", line_strobe, e_line);
      chk(frame_strobe == e_frame, "R2 frame strobe", frame_strobe, e_frame);
      if (!df_mode) begin
        if (e_frame) m_df = !m_df;
      end else if (e_line) begin
        if (m_dl == int'(df_rate)) begin m_df = !m_df; m_dl = 0; end
        else m_dl++;
      end
      if (e_line) begin
        m_grp = 0;
        m_ln = e_frame ? 0 : m_ln + 1;
      end else m_grp++;
      if (e_frame) begin
        m_addr = fb_start; m_idx = 0; m_frames++;
        if (freeze_req) m_halt = 1;
      end else begin
        m_idx++;
        if (m_idx == 8) begin
          m_idx = 0;
          m_addr = (int'(m_addr) + 4 >= int'(fb_end)) ? fb_start : m_addr + 16'd4;
        end
      end
    end else begin
      chk(pnl_data == 0 && !line_strobe && !frame_strobe, "R3 idle between nibbles",
          {pnl_data, line_strobe, frame_strobe}, 0);
    end
    if (!vid_en) begin m_halt = 0; m_df = 0; m_dl = 0; end
    if (!run_in) begin m_grp = 0; m_ln = 0; m_idx = 0; m_addr = fb_start; end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_frames(input int n, input string tag);
    int tgt = m_frames + n;
    int t = 0;
    while (m_frames < tgt && t < 4000) begin @(posedge clk); t++; end
    #2;
    chk(m_frames >= tgt, tag, m_frames, tgt);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    finish_up();
  end

  initial begin
    int t0;
    step(3);
    @(negedge clk);
    chk(!pix_clk && !mem_req && df_out == 0 && pnl_data == 0, "R6 reset state", {pix_clk, mem_req, df_out}, 0);
    step(1);
    rst_n = 1;
    step(2);

    // mono 16x4: 4 nibbles per line, 4 lines, frame bias
    vid_en = 1; disp_on = 1;
    wait_frames(3, "R1/R2/R8 mono frames");

    // 8-bit unsplit 16x3: tripled groups, frame ends mid-word, inverted, slow memory
    vid_en = 0; step(3);
    depth_sel = 3; pnl_height = 3; invert = 1; lat = 2;
    step(2); vid_en = 1;
    wait_frames(3, "R1/R4 color frames");

    // 8-bit split 16x6, bias every 2 lines
    vid_en = 0; step(3);
    split_mode = 1; pnl_height = 6; df_mode = 1; df_rate = 1; invert = 0; lat = 1;
    step(2); vid_en = 1;
    wait_frames(3, "R2/R9 split frames");

    // 2-bit grey 32x2 with a one-word buffer window: end wrap mid-frame
    vid_en = 0; step(3);
    depth_sel = 1; split_mode = 0; pnl_width = 32; pnl_height = 2; df_mode = 0;
    fb_end = 16'h0104; lat = 0;
    step(2); vid_en = 1;
    wait_frames(3, "R5 end wrap frames");

    // display off alone stops refresh, restart at frame top
    step(5); disp_on = 0;
    t0 = m_ticks; step(20);
    chk(m_ticks == t0, "R6 no nibbles with display off", m_ticks, t0);
    disp_on = 1;
    wait_frames(2, "R6 restart frames");

    // freeze mid-frame: frame completes, then halt until enable is cycled
    depth_sel = 0; step(5);
    freeze_req = 1;
    wait_frames(1, "R10 frame completes before halt");
    t0 = m_ticks; step(40);
    chk(m_ticks == t0, "R10 halted after frame", m_ticks, t0);
    freeze_req = 0; step(30);
    chk(m_ticks == t0, "R11 clearing freeze alone does not resume", m_ticks, t0);
    vid_en = 0; step(3); vid_en = 1;
    wait_frames(2, "R11 resume after enable cycle");

    step(5);
    finish_up();
  end
endmodule